// File: doc/BRIEF.md
# Sync-Strobed Interleaved Serial Byte Receiver

This block is the receive half of a one-wire serial link between a controller and up to eight two-channel formatter modules. The controller raises a one-cycle strobe at a fixed rate of one per 20 or 80 clocks. With each strobe it names the module whose turn it is. That module answers on the shared data line with one bit from its first channel in the cycle after the strobe, then one bit from its second channel in the next cycle. The modules take turns in rotation, so 2 to 16 channels share the wire by time division.

The receiver collects the bits in arrival order and packs every eight of them, least significant first, into a byte. It then stores the byte in an internal 40-byte first-in first-out buffer that the host drains through a pop port. When the buffer is full, the receiver holds back the next strobe until space opens, so no byte is ever lost.

Top module: `tdm_sync_rx`

## Requirements
- R1: While reset is asserted and right after it, `sync_o` is 0, `empty_o` is 1 and `level_o` is 0.
- R2: While enabled and not stalled, `sync_o` is a single-cycle pulse. Consecutive pulses are exactly 20 cycles apart when `slow_sync_i` is 0 and 80 cycles apart when it is 1. The first pulse comes one cycle after `enable_i` rises.
- R3: If `sync_o` is high in cycle t, the receiver takes the bit on `sdata_i` in cycle t+1 and then the bit in cycle t+2. Bits fill a byte from bit 0 upward, so each byte holds the bits of four consecutive strobes.
- R4: Finished bytes are delivered on `rd_data_o` in arrival order. `pop_i` with `empty_o` low removes the head byte. `level_o` gives the byte count and never exceeds 40.
- R5: `dev_sel_o`, valid while `sync_o` is high, is 0 at the first strobe after reset and advances by one at each strobe, wrapping after M-1. M is `chan_count_i` divided by 2, rounded down.
- R6: When `level_o` is 40, no strobe is issued. After a pop frees a byte, strobes resume within a few cycles.
- R7: While `enable_i` is 0, no strobe is issued.
- R8: A pop while the buffer is empty has no effect: `level_o` stays 0 and later bytes still arrive in order.
- R9: A channel count of 0 or 1 is treated as 2 (M = 1). A count above 16 is treated as 16 (M = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the strobe generator |
| slow_sync_i | input | 1 | 0: strobe every 20 cycles, 1: every 80 |
| chan_count_i | input | 5 | Number of channels sharing the line |
| sdata_i | input | 1 | Shared serial data line |
| sync_o | output | 1 | Strobe to the formatter modules |
| dev_sel_o | output | 3 | Module addressed by the current strobe |
| pop_i | input | 1 | Remove the head byte |
| rd_data_o | output | 8 | Head byte of the buffer |
| empty_o | output | 1 | Buffer holds no byte |
| level_o | output | 6 | Number of bytes held |

## Verification
A byte push from the assembler and a host pop can hit the buffer on the same clock edge. In one run, the bench pops during the cycle after the second bit of every eighth strobe, which is the very cycle the assembled byte is written. The byte order and the final count then show whether the two updates combined without losing or duplicating a byte. The second collision is between the full-buffer stall and the strobe timer: a pop while the buffer is full must let exactly one more group of strobes through before the stall returns.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int FAST_PERIOD = 20;
  localparam int SLOW_PERIOD = 80;
  localparam int MAX_CHAN    = 16;
  localparam int FIFO_DEPTH  = 40;
  localparam int BYTE_W      = 8;
  localparam int MAX_MODS    = MAX_CHAN / 2;
  localparam int CNT_W       = $clog2(SLOW_PERIOD);
  localparam int CC_W        = $clog2(MAX_CHAN + 1);
  localparam int DEV_W       = $clog2(MAX_MODS);
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W       = $clog2(FIFO_DEPTH);
  localparam int BIT_W       = $clog2(BYTE_W);
endpackage

// File: rtl/tdm_sync_timer.sv
module tdm_sync_timer
  import tdm_rx_pkg::*;
#(
  parameter int FAST  = FAST_PERIOD,
  parameter int SLOW  = SLOW_PERIOD,
  parameter int MMODS = MAX_MODS,
  parameter int CW    = CNT_W,
  parameter int CCW   = CC_W,
  parameter int DW    = DEV_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_i,
  input  logic           slow_i,
  input  logic [CCW-1:0] chan_i,
  input  logic           full_i,
  output logic           sync_o,
  output logic [DW-1:0]  dev_o
);
  localparam int MW = DW + 1;

  logic [CW-1:0]  cnt_q, cnt_d, last_cnt;
  logic           sync_q, sync_d;
  logic [DW-1:0]  dev_q, dev_d;
  logic           dev_en;
  logic [CCW-1:0] half;
  logic [MW-1:0]  mods;

  // Number of modules taking turns, clamped to 1..MMODS
  always_comb begin
    half = chan_i >> 1;
    if (half == '0)
      mods = MW'(1);
    else if (half > CCW'(MMODS))
      mods = MW'(MMODS);
    else
      mods = MW'(half);
  end

  assign last_cnt = slow_i ? CW'(SLOW - 1) : CW'(FAST - 1);

  always_comb begin
    cnt_d  = cnt_q;
    sync_d = 1'b0;
    if (!enable_i) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      if (!full_i) begin
        sync_d = 1'b1;
        cnt_d  = CW'(1);
      end
    end else if (cnt_q >= last_cnt) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign dev_en = sync_q;
  always_comb begin
    if ({1'b0, dev_q} >= (mods - MW'(1)))
      dev_d = '0;
    else
      dev_d = dev_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dev_q <= '0;
    else if (dev_en)
      dev_q <= dev_d;
  end

  assign sync_o = sync_q;
  assign dev_o  = dev_q;

  p_sync_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> !sync_q);
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |=> !sync_q);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !sync_q);
  p_dev_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> ({1'b0, dev_q} < mods));
endmodule

// File: rtl/tdm_bit_assembler.sv
module tdm_bit_assembler
  import tdm_rx_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int IW = BIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          sdata_i,
  output logic          push_o,
  output logic [BW-1:0] byte_o
);
  logic          a_slot_q, b_slot_q;
  logic          take;
  logic [BW-1:0] shreg_q, shreg_d;
  logic [IW-1:0] bcnt_q, bcnt_d;
  logic          push_q, push_d;
  logic [BW-1:0] byte_q;

  assign take = a_slot_q | b_slot_q;

  // First bit lands in bit 0 after the eighth shift
  always_comb begin
    shreg_d = {sdata_i, shreg_q[BW-1:1]};
    bcnt_d  = bcnt_q + IW'(1);
    push_d  = take && (bcnt_q == IW'(BW - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_slot_q <= 1'b0;
      b_slot_q <= 1'b0;
      push_q   <= 1'b0;
    end else begin
      a_slot_q <= sync_i;
      b_slot_q <= a_slot_q;
      push_q   <= push_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
    end else if (take) begin
      shreg_q <= shreg_d;
      bcnt_q  <= bcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      byte_q <= '0;
    else if (push_d)
      byte_q <= shreg_d;
  end

  assign push_o = push_q;
  assign byte_o = byte_q;

  p_slot_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_slot_q |=> b_slot_q);
  p_push_after_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(b_slot_q));
endmodule

// File: rtl/tdm_byte_fifo.sv
module tdm_byte_fifo
  import tdm_rx_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int BW    = BYTE_W,
  parameter int LW    = LVL_W,
  parameter int PW    = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [BW-1:0] data_i,
  input  logic          pop_i,
  output logic [BW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [BW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_comb begin
    wr_d  = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    rd_d  = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    lvl_d = lvl_q;
    case ({do_push, do_pop})
      2'b10:   lvl_d = lvl_q + LW'(1);
      2'b01:   lvl_d = lvl_q - LW'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_d;
      if (do_pop)  rd_q <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  assign dout_o  = mem[rd_q];
  assign level_o = lvl_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (lvl_q == '0));
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
endmodule

// File: rtl/tdm_sync_rx.sv
module tdm_sync_rx
  import tdm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              slow_sync_i,
  input  logic [CC_W-1:0]   chan_count_i,
  input  logic              sdata_i,
  output logic              sync_o,
  output logic [DEV_W-1:0]  dev_sel_o,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              full;
  logic              push;
  logic [BYTE_W-1:0] byte_w;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tdm_sync_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_i (enable_i),
    .slow_i   (slow_sync_i),
    .chan_i   (chan_count_i),
    .full_i   (full),
    .sync_o   (sync_o),
    .dev_o    (dev_sel_o)
  );

  tdm_bit_assembler u_asm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sync_i  (sync_o),
    .sdata_i (sdata_i),
    .push_o  (push),
    .byte_o  (byte_w)
  );

  tdm_byte_fifo u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (push),
    .data_i  (byte_w),
    .pop_i   (pop_i),
    .dout_o  (rd_data_o),
    .empty_o (empty_o),
    .full_o  (full),
    .level_o (level_o)
  );
endmodule

// File: tb/tdm_sync_rx_tb_top.sv
module tdm_sync_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       slow = 1'b0;
  logic [4:0] chan_cnt = 5'd2;
  logic       sdata = 1'b0;
  logic       pop_main = 1'b0;
  logic       pop_dev = 1'b0;
  logic       pop;
  logic       sync_o;
  logic [2:0] dev_sel;
  logic [7:0] rd_data;
  logic       empty;
  logic [5:0] level;

  assign pop = pop_main | pop_dev;

  always #2.5 clk = ~clk;

  tdm_sync_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable),
    .slow_sync_i  (slow),
    .chan_count_i (chan_cnt),
    .sdata_i      (sdata),
    .sync_o       (sync_o),
    .dev_sel_o    (dev_sel),
    .pop_i        (pop),
    .rd_data_o    (rd_data),
    .empty_o      (empty),
    .level_o      (level)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Vector: [15] slow, [14] pop during run, [12:8] channel count, [7:0] bytes
  localparam logic [15:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b0, 5'd2,  8'd6},
    {1'b0, 1'b1, 1'b0, 5'd6,  8'd9},
    {1'b1, 1'b0, 1'b0, 5'd16, 8'd3},
    {1'b0, 1'b1, 1'b0, 5'd0,  8'd4},
    {1'b0, 1'b0, 1'b0, 5'd31, 8'd5},
    {1'b1, 1'b1, 1'b0, 5'd7,  8'd2}
  };

  int vec_id = 0;
  int mods_exp = 1;
  int period = 20;
  bit spacing_on = 0;
  bit pop_mode = 0;
  int s_idx = 0;
  int rcv_idx = 0;
  int cyc = 0;
  int last_sync = 0;
  int bw = 0;
  int b_sidx = 0;

  function automatic logic [7:0] gen_byte(int v, int k);
    return 8'((k * 37 + v * 11 + 5) & 255);
  endfunction

  function automatic logic gen_bit(int v, int n);
    logic [7:0] b;
    b = gen_byte(v, n >> 3);
    return b[n & 7];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Formatter model: first bit after the strobe, second one cycle later
  always @(negedge clk) begin
    if (!rst_n) begin
      s_idx = 0;
      bw = 0;
      pop_dev = 1'b0;
      sdata = 1'b0;
    end else begin
      pop_dev = 1'b0;
      if (bw > 0) begin
        bw--;
        if (bw == 1) sdata = gen_bit(vec_id, 2 * b_sidx + 1);
        if (bw == 0 && pop_mode && (b_sidx % 8 == 7) && !empty) begin
          check(rd_data == gen_byte(vec_id, rcv_idx), "R4 pop/push collision",
                rd_data, gen_byte(vec_id, rcv_idx));
          rcv_idx++;
          pop_dev = 1'b1;
        end
      end
      if (sync_o) begin
        check(int'(dev_sel) == s_idx % mods_exp, "R5/R9 dev_sel", dev_sel, s_idx % mods_exp);
        if (spacing_on && s_idx > 0)
          check(cyc - last_sync == period, "R2 spacing", cyc - last_sync, period);
        last_sync = cyc;
        sdata = gen_bit(vec_id, 2 * s_idx);
        b_sidx = s_idx;
        bw = 3;
        s_idx++;
      end
      cyc++;
    end
  end

  task automatic do_reset();
    enable = 1'b0;
    pop_main = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(int total, string req);
    repeat (10) @(negedge clk);
    while (!empty) begin
      check(rd_data == gen_byte(vec_id, rcv_idx), req, rd_data, gen_byte(vec_id, rcv_idx));
      rcv_idx++;
      pop_main = 1'b1;
      @(negedge clk);
      pop_main = 1'b0;
    end
    check(rcv_idx == total, "R4 byte count", rcv_idx, total);
    check(level == 0, "R4 level after drain", level, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_o == 1'b0, "R1 sync in reset", sync_o, 0);
    check(empty == 1'b1, "R1 empty in reset", empty, 1);
    check(level == 0, "R1 level in reset", level, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(empty == 1'b1 && level == 0, "R1 after release", level, 0);

    // R7: disabled means no strobe
    repeat (200) @(negedge clk);
    check(s_idx == 0, "R7 no strobe while disabled", s_idx, 0);

    // R8: pop on empty, then one byte still arrives intact
    pop_main = 1'b1;
    repeat (3) @(negedge clk);
    pop_main = 1'b0;
    @(negedge clk);
    check(level == 0 && empty, "R8 pop on empty", level, 0);
    vec_id = 7; mods_exp = 1; period = 20; spacing_on = 1; pop_mode = 0;
    rcv_idx = 0;
    enable = 1'b1;
    wait (s_idx == 4);
    @(negedge clk);
    enable = 1'b0;
    drain(1, "R8 data after empty pop");

    // Table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < 6; v++) begin
      do_reset();
      vec_id = v;
      slow = VECS[v][15];
      pop_mode = VECS[v][14];
      chan_cnt = VECS[v][12:8];
      mods_exp = int'(VECS[v][12:8]) / 2;
      if (mods_exp < 1) mods_exp = 1;
      if (mods_exp > 8) mods_exp = 8;
      period = slow ? 80 : 20;
      spacing_on = 1;
      rcv_idx = 0;
      check(s_idx == 0, "R1 no strobe after reset", s_idx, 0);
      enable = 1'b1;
      wait (s_idx == 4 * int'(VECS[v][7:0]));
      @(negedge clk);
      enable = 1'b0;
      drain(int'(VECS[v][7:0]), "R3 byte data");
    end

    // R6: full buffer stalls strobes
    do_reset();
    vec_id = 6; slow = 1'b0; chan_cnt = 5'd2; mods_exp = 1; period = 20;
    spacing_on = 0; pop_mode = 0; rcv_idx = 0;
    enable = 1'b1;
    wait (level == 40);
    @(negedge clk);
    check(s_idx == 160, "R6 strobes to fill", s_idx, 160);
    repeat (300) @(negedge clk);
    check(s_idx == 160, "R6 stalled while full", s_idx, 160);
    check(level == 40, "R4 level capped", level, 40);
    check(rd_data == gen_byte(6, 0), "R4 head byte", rd_data, gen_byte(6, 0));
    rcv_idx = 1;
    pop_main = 1'b1;
    @(negedge clk);
    pop_main = 1'b0;
    repeat (5) @(negedge clk);
    check(s_idx == 161, "R6 resume after pop", s_idx, 161);
    wait (s_idx == 164);
    repeat (20) @(negedge clk);
    check(level == 40, "R6 refilled", level, 40);
    repeat (100) @(negedge clk);
    check(s_idx == 164, "R6 stalled again", s_idx, 164);
    enable = 1'b0;
    drain(41, "R6 data order after stall");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule